// File: doc/BRIEF.md
# Secure Second-Core Boot Hold and Wake Controller

This block controls the reset release and clock gating of a second, secure processor core in a dual-core system. After power-on or pin reset, and after a wake from standby, the second core stays in reset until one of two things happens. The first core can set a software boot-request bit. Or, when the system is secure, a security monitor can report an illegal access. A sticky boot-source flag records which of the two started the core. Software on the second core reads this flag to choose between running its normal application and handling the illegal access.

The second core can request deep stop. If it was started from reset by an illegal access, that request sends it back into reset and clears the flag. In every other case the core parks in deep stop with its clock gated. From deep stop the core is woken by a normal wakeup event (flag set to 1) or by a secure illegal access (flag set to 0). This happens while the rest of the system stays in run mode, so no system-wide low-power transition or reset is needed. When the system is not secure, illegal-access reports are ignored.

Top module: `sc_boot_hold`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters the held state: `core_hold`=1, `core_clk_en`=0 and `boot_src`=0.
- R2: In the held state, with `boot_req`=0 and no qualified illegal access, the core stays held.
- R3: In the held state, `boot_req`=1 moves the core to run on the next edge (`core_hold`=0, `core_clk_en`=1) with `boot_src`=1.
- R4: In the held state, with `secure_en`=1 and `illegal_evt`=1 (and `boot_req`=0), the core runs on the next edge with `boot_src`=0.
- R5: When `boot_req` and a qualified illegal access arrive in the same held cycle, the boot request wins and `boot_src`=1.
- R6: A core running after an illegal-access start from reset that raises `dstop_req` returns to the held state on the next edge, with `boot_src`=0.
- R7: A running core in any other case that raises `dstop_req` enters deep stop (`core_hold`=0, `core_clk_en`=0). `boot_src` is kept, and the core stays there until it is woken.
- R8: In deep stop, `wake_evt`=1 returns the core to run on the next edge with `boot_src`=1, without passing through the held state. It also wins over a simultaneous illegal access.
- R9: In deep stop, a secure illegal access (`wake_evt`=0) returns the core to run with `boot_src`=0. A later `dstop_req` puts it back into deep stop, not into the held state.
- R10: With `secure_en`=0, `illegal_evt` has no effect in the held state or in deep stop.
- R11: While the core is running, `illegal_evt` has no effect on the state or on `boot_src`.
- R12: `stby_wake`=1 moves the block to the held state with `boot_src`=0 on the next edge from any state. It takes priority over every other request except reset.
- R13: `core_hold` and `core_clk_en` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on/pin reset |
| boot_req | input | 1 | Software boot-request bit from the first core (level) |
| secure_en | input | 1 | System security enabled |
| illegal_evt | input | 1 | Illegal-access report, one cycle per event |
| dstop_req | input | 1 | Second core asks to enter deep stop |
| wake_evt | input | 1 | Normal wakeup event for a core in deep stop |
| stby_wake | input | 1 | System wake from standby; restarts the boot sequence |
| core_hold | output | 1 | Holds the second core in reset |
| core_clk_en | output | 1 | Second-core clock run enable |
| boot_src | output | 1 | Sticky start cause: 1 boot request/wake, 0 illegal access |

## Verification
Two start causes can fall in the same cycle. A boot request can meet an illegal access while the core is held, and a normal wake can meet an illegal access while it is in deep stop. The bench raises both inputs in a single cycle and expects the core to run with the flag at 1. In a separate step it raises a standby wake together with a deep-stop request and expects the held state with the flag cleared. A scoreboard compares the three outputs one cycle after each stimulus.

// File: rtl/sc_boot_pkg.sv
// Package: shared types for the secure second-core boot hold controller.
// Assumes: three core states suffice; encodings are internal only.
package sc_boot_pkg;

    localparam int ST_W = 2;

    typedef enum logic [ST_W-1:0] {
        ST_HELD  = 2'b00,
        ST_RUN   = 2'b01,
        ST_DSTOP = 2'b10
    } core_st_e;

    // Qualified requests seen by the state machine in one cycle.
    typedef struct packed {
        logic boot;     // boot request level
        logic illegal;  // illegal access, already gated by security
        logic wake;     // normal wakeup from deep stop
        logic dstop;    // core asks for deep stop
        logic stby;     // standby wake restart
    } evt_t;

endpackage

// File: rtl/sc_evt_qual.sv
// Module: sc_evt_qual
// Purpose: bundles raw requests and drops illegal-access reports when the
// system is not secure.
// Assumes: all inputs are already synchronous to clk.
module sc_evt_qual
    import sc_boot_pkg::*;
(
    input  logic boot_req,
    input  logic secure_en,
    input  logic illegal_evt,
    input  logic dstop_req,
    input  logic wake_evt,
    input  logic stby_wake,
    output evt_t evt
);

    // Gate the illegal path with security and pack the request set.
    always_comb begin
        evt.boot    = boot_req;
        evt.illegal = illegal_evt & secure_en;
        evt.wake    = wake_evt;
        evt.dstop   = dstop_req;
        evt.stby    = stby_wake;
    end

endmodule

// File: rtl/sc_boot_fsm.sv
// Module: sc_boot_fsm
// Purpose: core state, sticky boot-source flag and start-origin tracking.
// Assumes: synchronous active-low reset; standby wake outranks everything
// except reset; boot/wake outrank illegal access.
module sc_boot_fsm
    import sc_boot_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  evt_t     evt,
    output core_st_e state,
    output logic     src_flag
);

    core_st_e st_nxt;
    logic     flag_nxt;
    logic     from_rst_q;   // 1 when the current run began from held
    logic     from_rst_nxt;

    // Next-state selection by current state and request priority.
    always_comb begin
        st_nxt       = state;
        flag_nxt     = src_flag;
        from_rst_nxt = from_rst_q;
        if (evt.stby) begin
            st_nxt       = ST_HELD;
            flag_nxt     = 1'b0;
            from_rst_nxt = 1'b1;
        end else begin
            unique case (state)
                ST_HELD: begin
                    if (evt.boot) begin
                        st_nxt       = ST_RUN;
                        flag_nxt     = 1'b1;
                        from_rst_nxt = 1'b1;
                    end else if (evt.illegal) begin
                        st_nxt       = ST_RUN;
                        flag_nxt     = 1'b0;
                        from_rst_nxt = 1'b1;
                    end
                end
                ST_RUN: begin
                    if (evt.dstop) begin
                        if (!src_flag && from_rst_q) begin
                            st_nxt   = ST_HELD;
                            flag_nxt = 1'b0;
                        end else begin
                            st_nxt = ST_DSTOP;
                        end
                    end
                end
                ST_DSTOP: begin
                    if (evt.wake) begin
                        st_nxt       = ST_RUN;
                        flag_nxt     = 1'b1;
                        from_rst_nxt = 1'b0;
                    end else if (evt.illegal) begin
                        st_nxt       = ST_RUN;
                        flag_nxt     = 1'b0;
                        from_rst_nxt = 1'b0;
                    end
                end
                default: begin
                    st_nxt       = ST_HELD;
                    flag_nxt     = 1'b0;
                    from_rst_nxt = 1'b1;
                end
            endcase
        end
    end

    // State registers with synchronous reset to held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_HELD;
            src_flag   <= 1'b0;
            from_rst_q <= 1'b1;
        end else begin
            state      <= st_nxt;
            src_flag   <= flag_nxt;
            from_rst_q <= from_rst_nxt;
        end
    end

endmodule

// File: rtl/sc_out_dec.sv
// Module: sc_out_dec
// Purpose: turns the core state into reset-hold and clock-run controls.
// Assumes: state comes straight from registers, so outputs are glitch-safe.
module sc_out_dec
    import sc_boot_pkg::*;
(
    input  core_st_e state,
    output logic     hold,
    output logic     clk_en
);

    // One-hot style decode of the two controls.
    always_comb begin
        hold   = (state == ST_HELD);
        clk_en = (state == ST_RUN);
    end

endmodule

// File: rtl/sc_boot_hold.sv
// Module: sc_boot_hold (top)
// Purpose: reset-hold and wake control for a secure second core, with a
// sticky flag telling a boot/wake request apart from an illegal access.
// Assumes: all inputs synchronous to clk; rst_n is synchronous active-low.
module sc_boot_hold
    import sc_boot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic boot_req,
    input  logic secure_en,
    input  logic illegal_evt,
    input  logic dstop_req,
    input  logic wake_evt,
    input  logic stby_wake,
    output logic core_hold,
    output logic core_clk_en,
    output logic boot_src
);

    evt_t     evt;
    core_st_e state;

    sc_evt_qual u_qual (
        .boot_req   (boot_req),
        .secure_en  (secure_en),
        .illegal_evt(illegal_evt),
        .dstop_req  (dstop_req),
        .wake_evt   (wake_evt),
        .stby_wake  (stby_wake),
        .evt        (evt)
    );

    sc_boot_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (evt),
        .state   (state),
        .src_flag(boot_src)
    );

    sc_out_dec u_dec (
        .state (state),
        .hold  (core_hold),
        .clk_en(core_clk_en)
    );

endmodule

// File: rtl/sc_boot_hold_chk.sv
// Module: sc_boot_hold_chk
// Purpose: port-level properties of sc_boot_hold, bound into the top.
// Assumes: deep stop is visible as core_hold=0 and core_clk_en=0.
module sc_boot_hold_chk (
    input logic clk,
    input logic rst_n,
    input logic boot_req,
    input logic secure_en,
    input logic illegal_evt,
    input logic dstop_req,
    input logic wake_evt,
    input logic stby_wake,
    input logic core_hold,
    input logic core_clk_en,
    input logic boot_src
);

    // Controls are mutually exclusive.
    assert_excl_ctrl_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_hold && core_clk_en));

    // Boot request releases a held core with the flag set.
    assert_boot_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (core_hold && boot_req && !stby_wake) |=> (core_clk_en && boot_src));

    // Secure illegal access starts a held core with the flag clear.
    assert_illegal_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (core_hold && !boot_req && secure_en && illegal_evt && !stby_wake)
        |=> (core_clk_en && !boot_src));

    // Non-secure illegal reports leave a held core held.
    assert_nonsec_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (core_hold && !boot_req && !secure_en && !stby_wake) |=> core_hold);

    // Wake from deep stop runs the core with the flag set.
    assert_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_hold && !core_clk_en && wake_evt && !stby_wake)
        |=> (core_clk_en && boot_src));

    // Illegal access while running changes nothing.
    assert_run_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (core_clk_en && !dstop_req && !stby_wake) |=> (core_clk_en && $stable(boot_src)));

    // Standby wake always lands in held with the flag clear.
    assert_stby_R12: assert property (@(posedge clk) disable iff (!rst_n)
        stby_wake |=> (core_hold && !boot_src));

endmodule

bind sc_boot_hold sc_boot_hold_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .boot_req   (boot_req),
    .secure_en  (secure_en),
    .illegal_evt(illegal_evt),
    .dstop_req  (dstop_req),
    .wake_evt   (wake_evt),
    .stby_wake  (stby_wake),
    .core_hold  (core_hold),
    .core_clk_en(core_clk_en),
    .boot_src   (boot_src)
);

// File: tb/sim_sc_boot_hold.sv
// Bench: scoreboard for sc_boot_hold. The driver pushes the expected
// {core_hold, core_clk_en, boot_src} per step; the monitor compares mid-cycle.
module sim_sc_boot_hold;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic boot_req = 1'b0, secure_en = 1'b1, illegal_evt = 1'b0;
    logic dstop_req = 1'b0, wake_evt = 1'b0, stby_wake = 1'b0;
    logic core_hold, core_clk_en, boot_src;

    int n_chk = 0;
    int n_fail = 0;
    bit reported = 1'b0;
    bit [2:0] q_exp[$];
    string    q_tag[$];

    always #10 clk = ~clk;   // 50 MHz

    sc_boot_hold u0 (
        .clk(clk), .rst_n(rst_n), .boot_req(boot_req), .secure_en(secure_en),
        .illegal_evt(illegal_evt), .dstop_req(dstop_req), .wake_evt(wake_evt),
        .stby_wake(stby_wake), .core_hold(core_hold), .core_clk_en(core_clk_en),
        .boot_src(boot_src)
    );

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Driver: apply one cycle of inputs at the falling edge, push expectation.
    task automatic step(input bit r, input bit b, input bit s, input bit i,
                        input bit d, input bit w, input bit sb,
                        input bit [2:0] exp, input string tag);
        @(negedge clk);
        rst_n = r; boot_req = b; secure_en = s; illegal_evt = i;
        dstop_req = d; wake_evt = w; stby_wake = sb;
        q_exp.push_back(exp);
        q_tag.push_back(tag);
    endtask

    // Monitor: mid-cycle after each rising edge, pop and compare.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q_exp.size() > 0) begin
                bit [2:0] e;
                string t;
                bit [2:0] a;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                a = {core_hold, core_clk_en, boot_src};
                n_chk++;
                if (a !== e) begin
                    n_fail++;
                    $display("FAIL %s: {hold,run,src} actual %b expected %b", t, a, e);
                end
                n_chk++;
                if (core_hold && core_clk_en) begin
                    n_fail++;
                    $display("FAIL R13: hold and run both 1, actual %b expected not 11",
                             {core_hold, core_clk_en});
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #4000000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    // Stimulus: r b s i d w sb  expected {hold,run,src}
    initial begin
        step(0,0,1,0,0,0,0, 3'b100, "R1 reset");
        step(0,1,1,1,0,0,0, 3'b100, "R1 reset ignores requests");
        step(1,0,1,0,0,0,0, 3'b100, "R2 held");
        step(1,0,1,0,0,0,0, 3'b100, "R2 held");
        step(1,1,1,0,0,0,0, 3'b011, "R3 boot");
        step(1,1,1,1,0,0,0, 3'b011, "R11 illegal in run");
        step(1,1,1,0,1,0,0, 3'b001, "R7 deep stop");
        step(1,1,1,0,0,0,0, 3'b001, "R7 stays in deep stop");
        step(1,1,0,1,0,0,0, 3'b001, "R10 non-secure in deep stop");
        step(1,1,1,0,0,1,0, 3'b011, "R8 wake");
        step(1,1,1,0,1,0,0, 3'b001, "R7 deep stop again");
        step(1,1,1,1,0,0,0, 3'b010, "R9 illegal wake");
        step(1,1,1,0,1,0,0, 3'b000, "R9 back to deep stop");
        step(1,1,1,1,0,1,0, 3'b011, "R8 wake beats illegal");
        step(1,1,1,0,1,0,1, 3'b100, "R12 standby beats deep stop");
        step(1,0,1,0,0,0,0, 3'b100, "R2 held after standby");
        step(1,0,0,1,0,0,0, 3'b100, "R10 non-secure in held");
        step(1,0,1,1,0,0,0, 3'b010, "R4 illegal start");
        step(1,0,1,1,0,0,0, 3'b010, "R11 illegal in run");
        step(1,0,1,0,1,0,0, 3'b100, "R6 back to held");
        step(1,1,1,1,0,0,0, 3'b011, "R5 boot beats illegal");
        step(1,1,1,0,1,0,0, 3'b001, "R7 deep stop after boot");
        step(1,0,1,0,0,0,1, 3'b100, "R12 standby from deep stop");
        step(1,1,1,0,0,0,0, 3'b011, "R3 boot after standby");
        step(0,1,1,0,0,0,0, 3'b100, "R1 reset from run");
        @(negedge clk);
        @(negedge clk);
        report();
    end

endmodule